// File: doc/BRIEF.md
# Rotating-Counter Command Arbiter

This block merges command requests from several ports into one shared command queue, such as the queue in front of a memory controller. Each port presents a request, a command word and a flag that marks the command as a read. A rotating counter names the port that has first claim in a cycle. When that port is idle, the search moves on in rotating order and the first requesting port wins. At most one port is granted per cycle, and none is granted while the queue reports full. The counter steps by exactly one on every accepted command, whichever port won. It does not jump past the winner, so every requester is served within N accepted commands.

For each accepted read command the block stores the number of the winning port in a small tag FIFO. Each returning read beat pops the oldest tag, and the beat is marked valid only toward that port. Receiving ports are assumed always ready. Write data goes from the ports to the core directly and does not pass through this block.

Top module: `cmd_arb`

## Requirements
- R1: A synchronous active-high reset sets the counter to port 0, empties the tag FIFO and clears `tag_err_o`.
- R2: `gnt_o` is one-hot or zero, grants only a requesting port, and is zero when no port requests.
- R3: If the port named by the counter requests and `q_full_i` is low, that port is granted in the same cycle.
- R4: If the named port is idle, the grant goes to the first requesting port found by walking upward from the counter value, wrapping from port N-1 to port 0.
- R5: Each accepted command advances the counter by exactly one, wrapping from N-1 to 0, whichever port won. A port that wins because the counter named it can win again on the next cycle if the counter has moved to an idle port and the search reaches it again.
- R6: While `q_full_i` is high, no grant is issued and the counter keeps its value.
- R7: When exactly one port requests and the queue is not full, that port is granted on every such cycle.
- R8: `q_valid_o` is high exactly when a grant is issued, and `q_cmd_o` then carries the granted port's command word.
- R9: An accepted command whose `cmd_rd_i` bit is 1 pushes the winner's port number into the tag FIFO. A command whose bit is 0 pushes nothing. Each `rdata_valid_i` beat pops the oldest tag and raises bit [tag] of `rdata_vld_o`. When the FIFO is empty, `rdata_vld_o` stays zero.
- R10: A read accepted while the tag FIFO already holds TAG_DEPTH entries and no pop occurs in that cycle is dropped and sets `tag_err_o`. The flag stays set until reset.
- R11: A port that holds its request is granted before N further commands from other ports are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NPORT | Per-port command request |
| cmd_i | input | NPORT*CMD_W | Per-port command words; port p uses bits [p*CMD_W +: CMD_W] |
| cmd_rd_i | input | NPORT | Per-port flag, 1 = command is a read |
| q_full_i | input | 1 | Command queue cannot accept a command |
| gnt_o | output | NPORT | Grant vector, combinational |
| q_valid_o | output | 1 | Command presented to the queue this cycle |
| q_cmd_o | output | CMD_W | Granted command word |
| rdata_valid_i | input | 1 | A read data beat is returning |
| rdata_i | input | DATA_W | Returning read data |
| rdata_o | output | DATA_W | Read data sent to all ports |
| rdata_vld_o | output | NPORT | One-hot destination valid for the returning beat |
| tag_err_o | output | 1 | Sticky tag FIFO overflow flag |

## Verification
The assertions check the cycle-local rules on every cycle: the grant shape, no grant while full, a lone requester always granted, queue valid matching the grant, a one-step counter advance with wrap, the counter holding while full, the sticky error flag, and a per-port bound on how many other commands can be accepted while a request waits. Only the bench's scenarios can show the exact winner order that comes from the counter history. These include the case where the same port wins twice because the counter moved only one step. The bench also shows that read beats return to ports in command order, that write commands take no tag, and that an overflow drops its tag while the older tags still drain correctly.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;

    // Width of an index into n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cmd_arb_pick.sv
// Combinational rotating search: first requester at or after the start port.
module cmd_arb_pick #(
    parameter int NPORT = 4,
    localparam int PW   = cmd_arb_pkg::idx_width(NPORT)
) (
    input  logic [NPORT-1:0] req_i,
    input  logic [PW-1:0]    start_i,
    input  logic             en_i,
    output logic [NPORT-1:0] gnt_o
);

    always_comb begin
        logic found;
        gnt_o = '0;
        found = 1'b0;
        for (int off = 0; off < NPORT; off++) begin
            int idx;
            idx = int'(start_i) + off;
            if (idx >= NPORT) idx = idx - NPORT;
            if (en_i && !found && req_i[idx]) begin
                gnt_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmd_arb_tagq.sv
// FIFO of port numbers for outstanding reads, sticky overflow flag.
module cmd_arb_tagq #(
    parameter int DEPTH = 8,
    parameter int W     = 2,
    localparam int AW   = cmd_arb_pkg::idx_width(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] push_id_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         err_o
);

    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
        logic          err;
    } tq_state_t;

    tq_state_t     s_d, s_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_i && (s_q.cnt != '0);
        do_push = push_i && ((s_q.cnt != FULL_CNT) || do_pop);
        if (push_i && !do_push) s_d.err = 1'b1;
        if (do_push) s_d.wr = (s_q.wr == LAST_IX) ? '0 : s_q.wr + 1'b1;
        if (do_pop)  s_d.rd = (s_q.rd == LAST_IX) ? '0 : s_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= push_id_i;
    end

    assign head_o  = mem_q[s_q.rd];
    assign empty_o = (s_q.cnt == '0);
    assign err_o   = s_q.err;

endmodule

// File: rtl/cmd_arb.sv
// Round-robin command arbiter with queue back-pressure and read tag routing.
module cmd_arb #(
    parameter int NPORT     = 4,
    parameter int CMD_W     = 32,
    parameter int DATA_W    = 32,
    parameter int TAG_DEPTH = 8,
    localparam int PW       = cmd_arb_pkg::idx_width(NPORT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT-1:0]       req_i,
    input  logic [NPORT*CMD_W-1:0] cmd_i,
    input  logic [NPORT-1:0]       cmd_rd_i,
    input  logic                   q_full_i,
    output logic [NPORT-1:0]       gnt_o,
    output logic                   q_valid_o,
    output logic [CMD_W-1:0]       q_cmd_o,
    input  logic                   rdata_valid_i,
    input  logic [DATA_W-1:0]      rdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [NPORT-1:0]       rdata_vld_o,
    output logic                   tag_err_o
);

    localparam logic [PW-1:0] LAST_PORT = PW'(NPORT - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_state_t;

    arb_state_t     s_d, s_q;
    logic [PW-1:0]  ptr_q;
    logic [PW-1:0]  win_id;
    logic           win_rd;
    logic           accept;
    logic [PW-1:0]  tag_head;
    logic           tag_empty;

    assign ptr_q = s_q.ptr;

    cmd_arb_pick #(.NPORT(NPORT)) u_pick (
        .req_i   (req_i),
        .start_i (s_q.ptr),
        .en_i    (!q_full_i),
        .gnt_o   (gnt_o)
    );

    // Winner encode and command mux (one-hot AND-OR).
    always_comb begin
        win_id  = '0;
        win_rd  = 1'b0;
        q_cmd_o = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (gnt_o[p]) begin
                win_id  = PW'(p);
                win_rd  = cmd_rd_i[p];
                q_cmd_o = q_cmd_o | cmd_i[p*CMD_W +: CMD_W];
            end
        end
    end

    assign accept    = |gnt_o;
    assign q_valid_o = accept;

    always_comb begin
        s_d = s_q;
        if (accept) s_d.ptr = (s_q.ptr == LAST_PORT) ? '0 : s_q.ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    cmd_arb_tagq #(.DEPTH(TAG_DEPTH), .W(PW)) u_tagq (
        .clk       (clk),
        .rst       (rst),
        .push_i    (accept && win_rd),
        .push_id_i (win_id),
        .pop_i     (rdata_valid_i),
        .head_o    (tag_head),
        .empty_o   (tag_empty),
        .err_o     (tag_err_o)
    );

    assign rdata_o = rdata_i;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_route
            assign rdata_vld_o[p] = rdata_valid_i && !tag_empty && (tag_head == PW'(p));
        end
    endgenerate

endmodule

// File: rtl/cmd_arb_chk.sv
module cmd_arb_chk #(
    parameter int NPORT = 4,
    parameter int PW    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] req_i,
    input logic             q_full_i,
    input logic [NPORT-1:0] gnt_o,
    input logic             q_valid_o,
    input logic             rdata_valid_i,
    input logic [NPORT-1:0] rdata_vld_o,
    input logic             tag_err_o,
    input logic [PW-1:0]    ptr_q
);

    localparam logic [PW-1:0] LAST_PORT = PW'(NPORT - 1);
    localparam int CW = $clog2(NPORT + 1) + 1;

    a_r2_gnt_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_o));
    a_r2_gnt_requested: assert property (@(posedge clk) disable iff (rst) (gnt_o & ~req_i) == '0);
    a_r6_full_no_gnt: assert property (@(posedge clk) disable iff (rst) q_full_i |-> gnt_o == '0);
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst) q_full_i |=> ptr_q == $past(ptr_q));
    a_r7_single_req: assert property (@(posedge clk) disable iff (rst)
        ($countones(req_i) == 1 && !q_full_i) |-> gnt_o == req_i);
    a_r8_valid_match: assert property (@(posedge clk) disable iff (rst) q_valid_o == (gnt_o != '0));
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        q_valid_o |=> ptr_q == (($past(ptr_q) == LAST_PORT) ? '0 : $past(ptr_q) + 1'b1));
    a_r9_route_onehot: assert property (@(posedge clk) disable iff (rst)
        (rdata_vld_o != '0) |-> (rdata_valid_i && $onehot(rdata_vld_o)));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst) tag_err_o |=> tag_err_o);

    // R11: count commands accepted for others while a request waits.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_wait
            logic [CW-1:0] wait_q;
            always_ff @(posedge clk) begin
                if (rst || !req_i[p] || gnt_o[p]) wait_q <= '0;
                else if (q_valid_o)              wait_q <= wait_q + 1'b1;
            end
            a_r11_no_lockout: assert property (@(posedge clk) disable iff (rst) wait_q < CW'(NPORT));
        end
    endgenerate

endmodule

bind cmd_arb cmd_arb_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .q_full_i      (q_full_i),
    .gnt_o         (gnt_o),
    .q_valid_o     (q_valid_o),
    .rdata_valid_i (rdata_valid_i),
    .rdata_vld_o   (rdata_vld_o),
    .tag_err_o     (tag_err_o),
    .ptr_q         (ptr_q)
);

// File: tb/cmd_arb_tb.sv
`timescale 1ns/1ps
module cmd_arb_tb;

    localparam int NP = 4;
    localparam int CW = 16;
    localparam int DW = 32;
    localparam int TD = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   req = '0;
    logic [NP*CW-1:0] cmd;
    logic [NP-1:0]   rd = '0;
    logic            full = 1'b0;
    logic [NP-1:0]   gnt;
    logic            qv;
    logic [CW-1:0]   qcmd;
    logic            rv = 1'b0;
    logic [DW-1:0]   rdat = '0;
    logic [DW-1:0]   rdo;
    logic [NP-1:0]   rvld;
    logic            terr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    // Port p sends command word 16'hC0D0 + p.
    always_comb begin
        for (int p = 0; p < NP; p++) cmd[p*CW +: CW] = 16'hC0D0 + CW'(p);
    end

    cmd_arb #(.NPORT(NP), .CMD_W(CW), .DATA_W(DW), .TAG_DEPTH(TD)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .cmd_i(cmd), .cmd_rd_i(rd),
        .q_full_i(full), .gnt_o(gnt), .q_valid_o(qv), .q_cmd_o(qcmd),
        .rdata_valid_i(rv), .rdata_i(rdat), .rdata_o(rdo),
        .rdata_vld_o(rvld), .tag_err_o(terr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, then sample 1 ns later.
    task automatic drive(input logic [NP-1:0] r, input logic [NP-1:0] rdf,
                         input logic f, input logic v);
        @(negedge clk);
        req = r; rd = rdf; full = f; rv = v; rdat = 32'h5A00_0000 + 32'(total);
        #1;
    endtask

    // {req[3:0], full, expected gnt[3:0]}; sequence starts from counter 0.
    localparam logic [8:0] VEC [16] = '{
        {4'b1111, 1'b0, 4'b0001},  // R3: counter 0 granted
        {4'b1111, 1'b1, 4'b0000},  // R6: full, no grant, counter holds at 1
        {4'b1111, 1'b0, 4'b0010},  // R6: counter stayed at 1
        {4'b0001, 1'b0, 4'b0001},  // R4: skip 2,3, wrap to 0
        {4'b0001, 1'b0, 4'b0001},  // R7: lone requester
        {4'b0001, 1'b0, 4'b0001},  // R7: counter wrapped (R5)
        {4'b1100, 1'b0, 4'b0100},  // R4: from 1, find 2
        {4'b1100, 1'b0, 4'b0100},  // R5: counter now 2, port 2 again
        {4'b1100, 1'b0, 4'b1000},  // R5: counter 3
        {4'b0000, 1'b0, 4'b0000},  // R2: no request
        {4'b0110, 1'b1, 4'b0000},  // R6: full
        {4'b0110, 1'b0, 4'b0010},  // R4: counter 0, skip to 1
        {4'b0110, 1'b0, 4'b0010},  // R5: counter 1
        {4'b0110, 1'b0, 4'b0100},  // R3: counter 2
        {4'b1001, 1'b0, 4'b1000},  // R3: counter 3
        {4'b1001, 1'b0, 4'b0001}   // R5: wrapped to 0
    };

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: after reset, FIFO empty and no error.
        drive('0, '0, 1'b0, 1'b1);
        chk("R1 tag empty, beat unrouted", 32'(rvld), 32'h0);
        chk("R1 error clear", 32'(terr), 32'h0);
        chk("R2 no request no grant", 32'(gnt), 32'h0);

        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][8:5], '0, VEC[i][4], 1'b0);
            chk($sformatf("R3 R4 R5 R6 vector %0d grant", i), 32'(gnt), 32'(VEC[i][3:0]));
            chk($sformatf("R8 vector %0d valid", i), 32'(qv), 32'(VEC[i][3:0] != 0));
            for (int p = 0; p < NP; p++)
                if (VEC[i][p]) chk($sformatf("R8 vector %0d cmd", i), 32'(qcmd), 32'(16'hC0D0 + p));
        end

        // R9: reads from 2, 0, a write from 3, read from 1.
        drive(4'b0100, 4'b0100, 1'b0, 1'b0);
        drive(4'b0001, 4'b0001, 1'b0, 1'b0);
        drive(4'b1000, 4'b0000, 1'b0, 1'b0);
        chk("R9 write granted", 32'(gnt), 32'h8);
        drive(4'b0010, 4'b0010, 1'b0, 1'b0);
        drive('0, '0, 1'b0, 1'b1);
        chk("R9 first beat to port 2", 32'(rvld), 32'h4);
        chk("R9 data passes through", rdo, rdat);
        drive('0, '0, 1'b0, 1'b1);
        chk("R9 second beat to port 0", 32'(rvld), 32'h1);
        drive('0, '0, 1'b0, 1'b1);
        chk("R9 write took no tag, beat to port 1", 32'(rvld), 32'h2);
        drive('0, '0, 1'b0, 1'b1);
        chk("R9 empty FIFO gives no valid", 32'(rvld), 32'h0);

        // R10: overflow with depth 4.
        drive(4'b0010, 4'b0010, 1'b0, 1'b0);
        drive(4'b0100, 4'b0100, 1'b0, 1'b0);
        drive(4'b1000, 4'b1000, 1'b0, 1'b0);
        drive(4'b0001, 4'b0001, 1'b0, 1'b0);
        drive(4'b0100, 4'b0100, 1'b0, 1'b0);
        chk("R10 full FIFO no error yet", 32'(terr), 32'h0);
        drive('0, '0, 1'b0, 1'b0);
        chk("R10 overflow sets error", 32'(terr), 32'h1);
        drive('0, '0, 1'b0, 1'b1);
        chk("R10 drain port 1", 32'(rvld), 32'h2);
        drive('0, '0, 1'b0, 1'b1);
        chk("R10 drain port 2", 32'(rvld), 32'h4);
        drive('0, '0, 1'b0, 1'b1);
        chk("R10 drain port 3", 32'(rvld), 32'h8);
        drive('0, '0, 1'b0, 1'b1);
        chk("R10 drain port 0", 32'(rvld), 32'h1);
        drive('0, '0, 1'b0, 1'b1);
        chk("R10 dropped tag not routed", 32'(rvld), 32'h0);
        chk("R10 error sticky", 32'(terr), 32'h1);

        // R1: reset clears error, counter back to 0.
        drive(4'b0110, 4'b0110, 1'b0, 1'b0);
        drive(4'b0110, 4'b0110, 1'b0, 1'b0);
        rst = 1'b1;
        req = '0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset clears error", 32'(terr), 32'h0);
        drive(4'b1111, '0, 1'b0, 1'b1);
        chk("R1 counter back at port 0", 32'(gnt), 32'h1);
        chk("R1 reset empties FIFO", 32'(rvld), 32'h0);

        // R11: port 3 waits while others take grants; served within N.
        drive(4'b1111, '0, 1'b0, 1'b0);
        chk("R11 second grant port 1", 32'(gnt), 32'h2);
        drive(4'b1111, '0, 1'b0, 1'b0);
        chk("R11 third grant port 2", 32'(gnt), 32'h4);
        drive(4'b1111, '0, 1'b0, 1'b0);
        chk("R11 port 3 served", 32'(gnt), 32'h8);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule